// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of an 8-bit parallel NOR flash bus. It takes one request at a time over a valid/ready interface: program one byte, erase one sector, or erase the whole array. For each request it drives the chip-enable, write-enable and output-enable strobes, the address bus and the outbound data bus. It issues the unlock write sequence the flash needs before it accepts a change, then polls the target location until the internal operation has finished.

Completion uses the toggle-bit method. While the flash is busy, bit 6 of every read flips. Once two back-to-back reads show the same bit 6, the block makes two confirmation reads. It declares the operation finished only if those two reads return identical bytes, which guards against a read that lands on the instant the flash finishes. A limit on the number of status reads produces a timeout. After a program, the final read is compared with the requested byte.

All strobe widths are given in nanoseconds and converted to clock cycles from the clock period parameter. The same RTL therefore serves any system clock.

Top module: `flashProgCtrl`

## Requirements
- R1: While reset is asserted and after it is released, `flCeN`, `flWeN` and `flOeN` are high, `flDoe` is low, `reqReady` is high and `respValid` is low.
- R2: Each write below is an (address, data) pair in hex. A request with `reqOp`=0 (byte program) produces exactly four writes: (5555,AA), (2AAA,55), (5555,A0), (target, byte). A request with `reqOp`=1 (sector erase) produces exactly six writes: (5555,AA), (2AAA,55), (5555,80), (5555,AA), (2AAA,55), (target,30). A request with `reqOp`=2 (chip erase) produces the same six writes except that the last one is (5555,10). Upper address bits of command cycles are zero.
- R3: During every write, `flCeN` is low and `flDoe` is high while `flWeN` is low. `flWeN` stays low for at least ceil(WE_LOW_NS/CLK_NS) cycles and high for at least ceil(WE_HIGH_NS/CLK_NS) cycles between writes. Address and data stay unchanged from the falling edge of `flWeN` through that high time.
- R4: `flOeN` is never low while `flWeN` is low. The first status read starts no sooner than ceil(WE_HIGH_NS/CLK_NS)+ceil(OE_HOLD_NS/CLK_NS) cycles after the last `flWeN` rise. `flDoe` is low during reads.
- R5: Every status read holds `flCeN` and `flOeN` low for at least ceil(RD_NS/CLK_NS) cycles, with the request address on `flAddr`. Between reads, `flOeN` is high for at least ceil(RD_GAP_NS/CLK_NS) cycles.
- R6: The operation completes on the first read N such that reads N-3 and N-2 show equal bit 6 and reads N-1 and N are identical bytes, where read N-2 was not itself a confirmation read. If the confirmation bytes differ, polling resumes, comparing bit 6 against the last byte read.
- R7: `reqReady` is low from the cycle after acceptance until the response. `respValid` is a single-cycle pulse, and `reqReady` is high the cycle after it.
- R8: If POLL_LIMIT status reads pass without completion, the block responds with `respTimeout`=1 after exactly POLL_LIMIT reads.
- R9: `respMismatch` is 1 only for a completed byte program whose final read differs from the requested byte. Erases and timeouts report 0.
- R10: A request with `reqOp`=3 is ignored: no bus cycle starts, no response follows, and `reqReady` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 ignored |
| reqAddr | input | ADDR_W | Target byte / sector address, also the polled location |
| reqData | input | 8 | Byte to program |
| reqReady | output | 1 | Block idle, request accepted when valid |
| respValid | output | 1 | One-cycle completion pulse |
| respTimeout | output | 1 | Polling limit reached (valid with respValid) |
| respMismatch | output | 1 | Programmed byte read back wrong (valid with respValid) |
| flAddr | output | ADDR_W | Flash address bus |
| flDout | output | 8 | Data driven to the flash |
| flDoe | output | 1 | Drive enable for flDout |
| flDin | input | 8 | Data read from the flash |
| flCeN | output | 1 | Chip enable, active low |
| flOeN | output | 1 | Output enable, active low |
| flWeN | output | 1 | Write enable, active low |

## Verification
A wrong step counter or command table shows up at the pins within one write, as a bad (address, data) pair or a wrong number of write strobes. A bad poll-phase register shows up as a completion that comes one or two reads early or late, or never comes. That count of reads is checked exactly against a flash model that flips bit 6, including injected stalls of the toggle that fake a finish. Timer errors show as a strobe window shorter than its cycle budget on the very write or read where they occur.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } flashOpE;

  typedef enum logic [2:0] {
    S_IDLE, S_WLOW, S_WHIGH, S_OEGAP, S_RACT, S_RGAP, S_RESP
  } seqStateE;

  typedef enum logic [1:0] {
    PH_FIRST, PH_POLL, PH_CONF_A, PH_CONF_B
  } pollPhaseE;

  // strobes from control to datapath, decoded from the next state
  typedef struct packed {
    logic       latchReq;
    logic       loadCmd;
    logic [2:0] stepIdx;
    logic       loadPoll;
    logic       capture;
    logic       ceLow;
    logic       weLow;
    logic       oeLow;
    logic       driveData;
  } busStrobeT;

  function automatic int cycCeil(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/flashBusPath.sv
module flashBusPath
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WE_LOW_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobeT         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [1:0]        reqOp,
  input  logic [7:0]        flDin,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              flDoe,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              sameBit6,
  output logic              sameByte,
  output logic              matchReq
);

  localparam logic [14:0] UNLOCK_HI = 15'h5555;
  localparam logic [14:0] UNLOCK_LO = 15'h2AAA;
  localparam int RUN_W = $clog2(WE_LOW_CYC + 2);

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  flashOpE           opQ;
  logic [7:0]        prevQ;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      opQ   <= OP_PROG;
    end else if (strobe.latchReq) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      opQ   <= flashOpE'(reqOp);
    end
  end

  // command table; step 0 never depends on the latched request
  always_comb begin
    cmdAddr = '0;
    cmdData = 8'h00;
    case (strobe.stepIdx)
      3'd0, 3'd3: begin cmdAddr[14:0] = UNLOCK_HI; cmdData = 8'hAA; end
      3'd1, 3'd4: begin cmdAddr[14:0] = UNLOCK_LO; cmdData = 8'h55; end
      3'd2: begin
        cmdAddr[14:0] = UNLOCK_HI;
        cmdData = (opQ == OP_PROG) ? 8'hA0 : 8'h80;
      end
      default: begin
        if (opQ == OP_SECT) begin
          cmdAddr = addrQ;
          cmdData = 8'h30;
        end else begin
          cmdAddr[14:0] = UNLOCK_HI;
          cmdData = 8'h10;
        end
      end
    endcase
    if (opQ == OP_PROG && strobe.stepIdx == 3'd3) begin
      cmdAddr = addrQ;
      cmdData = dataQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flCeN  <= 1'b1;
      flWeN  <= 1'b1;
      flOeN  <= 1'b1;
      flDoe  <= 1'b0;
      flAddr <= '0;
      flDout <= '0;
      prevQ  <= '0;
    end else begin
      flCeN <= ~strobe.ceLow;
      flWeN <= ~strobe.weLow;
      flOeN <= ~strobe.oeLow;
      flDoe <= strobe.driveData;
      if (strobe.loadCmd) begin
        flAddr <= cmdAddr;
        flDout <= cmdData;
      end else if (strobe.loadPoll) begin
        flAddr <= addrQ;
      end
      if (strobe.capture) prevQ <= flDin;
    end
  end

  assign sameBit6 = (flDin[6] == prevQ[6]);
  assign sameByte = (flDin == prevQ);
  assign matchReq = (flDin == dataQ);

  // width of the current write-enable low pulse, saturating
  logic [RUN_W-1:0] weLowRun;
  always_ff @(posedge clk) begin
    if (!rstN)                        weLowRun <= '0;
    else if (flWeN)                   weLowRun <= '0;
    else if (weLowRun != {RUN_W{1'b1}}) weLowRun <= weLowRun + 1'b1;
  end

  p_we_with_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> (!flCeN && flDoe));

  p_we_low_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> (weLowRun >= RUN_W'(WE_LOW_CYC)));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDout)));

  p_no_oe_in_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> flOeN);

  p_read_undriven_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flOeN |-> (!flDoe && !flCeN));

endmodule

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flash_ctrl_pkg::*;
#(
  parameter int WE_LOW_CYC  = 2,
  parameter int WE_HIGH_CYC = 2,
  parameter int OE_HOLD_CYC = 1,
  parameter int RD_CYC      = 4,
  parameter int RD_GAP_CYC  = 2,
  parameter int POLL_LIMIT  = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output logic       respValid,
  output logic       respTimeout,
  output logic       respMismatch,
  input  logic       sameBit6,
  input  logic       sameByte,
  input  logic       matchReq,
  output busStrobeT  strobe
);

  localparam int TMR_W = $clog2(WE_LOW_CYC + WE_HIGH_CYC + OE_HOLD_CYC + RD_CYC + RD_GAP_CYC + 1);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  seqStateE   state, nState;
  pollPhaseE  ph, nPh;
  flashOpE    opQ, nOp;
  logic [TMR_W-1:0] tmr, nTmr;
  logic [2:0] step, nStep, lastStep;
  logic [CNT_W-1:0] cnt, nCnt;
  logic toQ, nTo, mmQ, nMm;
  logic accept, capture, done;

  assign lastStep = (opQ == OP_PROG) ? 3'd3 : 3'd5;

  always_comb begin
    nState  = state;
    nTmr    = (tmr != '0) ? tmr - 1'b1 : tmr;
    nStep   = step;
    nPh     = ph;
    nCnt    = cnt;
    nTo     = toQ;
    nMm     = mmQ;
    nOp     = opQ;
    accept  = 1'b0;
    capture = 1'b0;
    done    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid && reqOp != 2'd3) begin
          accept = 1'b1;
          nOp    = flashOpE'(reqOp);
          nState = S_WLOW;
          nTmr   = TMR_W'(WE_LOW_CYC - 1);
          nStep  = 3'd0;
          nTo    = 1'b0;
          nMm    = 1'b0;
        end
      end
      S_WLOW: begin
        if (tmr == '0) begin
          nState = S_WHIGH;
          nTmr   = TMR_W'(WE_HIGH_CYC - 1);
        end
      end
      S_WHIGH: begin
        if (tmr == '0) begin
          if (step == lastStep) begin
            nState = S_OEGAP;
            nTmr   = TMR_W'(OE_HOLD_CYC - 1);
          end else begin
            nStep  = step + 1'b1;
            nState = S_WLOW;
            nTmr   = TMR_W'(WE_LOW_CYC - 1);
          end
        end
      end
      S_OEGAP: begin
        if (tmr == '0) begin
          nState = S_RACT;
          nTmr   = TMR_W'(RD_CYC - 1);
          nCnt   = '0;
          nPh    = PH_FIRST;
        end
      end
      S_RACT: begin
        if (tmr == '0) begin
          capture = 1'b1;
          nCnt    = cnt + 1'b1;
          unique case (ph)
            PH_FIRST:  nPh = PH_POLL;
            PH_POLL:   if (sameBit6) nPh = PH_CONF_A;
            PH_CONF_A: nPh = PH_CONF_B;
            PH_CONF_B: begin
              if (sameByte) done = 1'b1;
              else          nPh = PH_POLL;
            end
          endcase
          if (done) begin
            nState = S_RESP;
            nMm    = (opQ == OP_PROG) && !matchReq;
          end else if (nCnt == CNT_W'(POLL_LIMIT)) begin
            nState = S_RESP;
            nTo    = 1'b1;
          end else begin
            nState = S_RGAP;
            nTmr   = TMR_W'(RD_GAP_CYC - 1);
          end
        end
      end
      S_RGAP: begin
        if (tmr == '0) begin
          nState = S_RACT;
          nTmr   = TMR_W'(RD_CYC - 1);
        end
      end
      S_RESP: nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      ph    <= PH_FIRST;
      opQ   <= OP_PROG;
      tmr   <= '0;
      step  <= '0;
      cnt   <= '0;
      toQ   <= 1'b0;
      mmQ   <= 1'b0;
    end else begin
      state <= nState;
      ph    <= nPh;
      opQ   <= nOp;
      tmr   <= nTmr;
      step  <= nStep;
      cnt   <= nCnt;
      toQ   <= nTo;
      mmQ   <= nMm;
    end
  end

  always_comb begin
    strobe.latchReq  = accept;
    strobe.loadCmd   = (nState == S_WLOW) && (state != S_WLOW);
    strobe.stepIdx   = nStep;
    strobe.loadPoll  = (nState == S_OEGAP) && (state != S_OEGAP);
    strobe.capture   = capture;
    strobe.ceLow     = (nState == S_WLOW) || (nState == S_RACT);
    strobe.weLow     = (nState == S_WLOW);
    strobe.oeLow     = (nState == S_RACT);
    strobe.driveData = (nState == S_WLOW) || (nState == S_WHIGH);
  end

  assign reqReady     = (state == S_IDLE);
  assign respValid    = (state == S_RESP);
  assign respTimeout  = toQ;
  assign respMismatch = mmQ;

  p_resp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (!respValid && reqReady));

  p_step_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WLOW) |-> (step <= lastStep));

  p_poll_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(POLL_LIMIT));

  p_timeout_at_limit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respTimeout) |-> (cnt == CNT_W'(POLL_LIMIT) && !respMismatch));

  p_mismatch_prog_r9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respMismatch) |-> (opQ == OP_PROG));

  p_ignore_op3_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && reqOp == 2'd3) |=> reqReady);

endmodule

// File: rtl/flashProgCtrl.sv
module flashProgCtrl
  import flash_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CLK_NS     = 20,
  parameter int WE_LOW_NS  = 40,
  parameter int WE_HIGH_NS = 30,
  parameter int OE_HOLD_NS = 10,
  parameter int RD_NS      = 70,
  parameter int RD_GAP_NS  = 25,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  output logic              reqReady,
  output logic              respValid,
  output logic              respTimeout,
  output logic              respMismatch,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              flDoe,
  input  logic [7:0]        flDin,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  localparam int WE_LOW_CYC  = cycCeil(WE_LOW_NS, CLK_NS);
  localparam int WE_HIGH_CYC = cycCeil(WE_HIGH_NS, CLK_NS);
  localparam int OE_HOLD_CYC = cycCeil(OE_HOLD_NS, CLK_NS);
  localparam int RD_CYC      = cycCeil(RD_NS, CLK_NS);
  localparam int RD_GAP_CYC  = cycCeil(RD_GAP_NS, CLK_NS);

  busStrobeT strobe;
  logic sameBit6, sameByte, matchReq;

  flashSeqCtrl #(
    .WE_LOW_CYC (WE_LOW_CYC),
    .WE_HIGH_CYC(WE_HIGH_CYC),
    .OE_HOLD_CYC(OE_HOLD_CYC),
    .RD_CYC     (RD_CYC),
    .RD_GAP_CYC (RD_GAP_CYC),
    .POLL_LIMIT (POLL_LIMIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqReady(reqReady),
    .respValid(respValid), .respTimeout(respTimeout), .respMismatch(respMismatch),
    .sameBit6(sameBit6), .sameByte(sameByte), .matchReq(matchReq),
    .strobe(strobe)
  );

  flashBusPath #(
    .ADDR_W    (ADDR_W),
    .WE_LOW_CYC(WE_LOW_CYC)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqData(reqData), .reqOp(reqOp), .flDin(flDin),
    .flAddr(flAddr), .flDout(flDout), .flDoe(flDoe),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN),
    .sameBit6(sameBit6), .sameByte(sameByte), .matchReq(matchReq)
  );

endmodule

// File: tb/tb_flashProgCtrl.sv
module tb_flashProgCtrl;

  localparam int LIMIT = 48;
  localparam int WL  = (40 + 19) / 20;
  localparam int WH  = (30 + 19) / 20;
  localparam int OEH = (10 + 19) / 20;
  localparam int RD  = (70 + 19) / 20;
  localparam int RG  = (25 + 19) / 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic reqReady, respValid, respTimeout, respMismatch;
  logic [15:0] flAddr;
  logic [7:0] flDout, flDin;
  logic flDoe, flCeN, flOeN, flWeN;

  always #10 clk = ~clk;

  flashProgCtrl #(.POLL_LIMIT(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .respValid(respValid), .respTimeout(respTimeout), .respMismatch(respMismatch),
    .flAddr(flAddr), .flDout(flDout), .flDoe(flDoe), .flDin(flDin),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] mem [1024];
  logic [15:0] logA [8];
  logic [7:0]  logD [8];
  int wc = 0, expW = 4, rdCnt = 0;
  int busyLeft = 0, plannedBusy = 0, glitchAt = 0, busyIdx = 0;
  int curOp = 0;
  logic togg = 1'b1, st7 = 1'b0;
  logic prevWe = 1'b1, prevOe = 1'b1;
  int v3 = 0, v4 = 0, v5 = 0;
  int weLowRun = 0, sinceWe = 1000, oeLowRun = 0, oeHighRun = 1000;
  logic [15:0] holdA = '0, curAddr = '0;
  logic [7:0] holdD = '0;

  assign flDin = (busyLeft > 0) ? {st7, togg, 6'b0} : mem[flAddr[9:0]];

  always @(negedge clk) begin
    cycles++;
    // write side
    if (!flWeN) begin
      if (weLowRun == 0) begin
        holdA = flAddr; holdD = flDout;
        if (sinceWe < WH) v3++;
      end
      if (flCeN || !flDoe) v3++;
      if (flAddr != holdA || flDout != holdD) v3++;
      if (!flOeN) v4++;
      weLowRun++;
    end else if (!prevWe) begin
      if (weLowRun < WL) v3++;
      if (flAddr != holdA || flDout != holdD) v3++;
      weLowRun = 0;
      sinceWe = 1;
      logA[wc & 7] = holdA; logD[wc & 7] = holdD;
      wc++;
      if (wc == expW) begin
        busyLeft = plannedBusy; togg = 1'b1; busyIdx = 0;
        if (curOp == 0) mem[holdA[9:0]] = mem[holdA[9:0]] & holdD;
        else for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
      end
    end else begin
      if (sinceWe < 1000) sinceWe++;
      if (sinceWe <= WH && (flAddr != holdA || flDout != holdD)) v3++;
    end
    // read side
    if (!flOeN) begin
      if (prevOe) begin
        if (rdCnt == 0 && sinceWe < WH + OEH) v4++;
        if (rdCnt > 0 && oeHighRun < RG) v5++;
      end
      if (flCeN || flAddr != curAddr) v5++;
      if (flDoe) v4++;
      oeLowRun++;
    end else if (!prevOe) begin
      if (oeLowRun < RD) v5++;
      oeLowRun = 0; oeHighRun = 1;
      rdCnt++;
      if (busyLeft > 0) begin
        busyIdx++;
        if (busyIdx != glitchAt) togg = ~togg;
        busyLeft--;
      end
    end else if (oeHighRun < 1000) oeHighRun++;
    prevWe = flWeN;
    prevOe = flOeN;
  end

  // ---------------- expected values ----------------
  function automatic logic [23:0] expCmd(int op, int i, logic [15:0] a, logic [7:0] d);
    if (op == 0 && i == 3) return {a, d};
    case (i)
      0, 3: return {16'h5555, 8'hAA};
      1, 4: return {16'h2AAA, 8'h55};
      2: return (op == 0) ? {16'h5555, 8'hA0} : {16'h5555, 8'h80};
      default: return (op == 1) ? {a, 8'h30} : {16'h5555, 8'h10};
    endcase
  endfunction

  // read number at which the toggle rule with confirmation completes, -1 on timeout
  function automatic int expReads(int busy, int glitch, logic s7, logic [7:0] fin);
    logic tg;
    logic [7:0] v, prv;
    int ph;
    tg = 1'b1; prv = 8'h00; ph = 0;
    for (int i = 1; i <= LIMIT; i++) begin
      if (i <= busy) begin
        v = {s7, tg, 6'b0};
        if (i != glitch) tg = ~tg;
      end else v = fin;
      case (ph)
        0: ph = 1;
        1: if (v[6] == prv[6]) ph = 2;
        2: ph = 3;
        default: begin
          if (v == prv) return i;
          ph = 1;
        end
      endcase
      prv = v;
    end
    return -1;
  endfunction

  task automatic doOp(input int op, input logic [15:0] a, input logic [7:0] d,
                      input int busy, input int glitch);
    logic [7:0] oldV, finV;
    int eR, waitC, badW, readyBad;
    bit expMm;
    oldV = mem[a[9:0]];
    finV = (op == 0) ? (oldV & d) : 8'hFF;
    busyLeft = 0; plannedBusy = busy; glitchAt = glitch; curOp = op;
    expW = (op == 0) ? 4 : 6; wc = 0; rdCnt = 0; curAddr = a;
    st7 = (op == 0) ? ~d[7] : 1'b0;
    v3 = 0; v4 = 0; v5 = 0;
    eR = expReads(busy, glitch, st7, finV);
    expMm = (op == 0) && (eR > 0) && (finV != d);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op[1:0]; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqData = ~d;
    waitC = 0; readyBad = 0;
    while (!respValid && waitC < 5000) begin
      if (reqReady) readyBad++;
      @(negedge clk);
      waitC++;
    end
    chk(respValid, "R7", "response arrived", int'(respValid), 1);
    chk(readyBad == 0, "R7", "ready low while busy", readyBad, 0);
    chk(respTimeout == (eR < 0), "R8", "timeout flag", int'(respTimeout), int'(eR < 0));
    chk(respMismatch == expMm, "R9", "mismatch flag", int'(respMismatch), int'(expMm));
    @(negedge clk);
    chk(!respValid && reqReady, "R7", "single pulse then ready", int'(respValid), 0);
    chk(rdCnt == ((eR < 0) ? LIMIT : eR), "R6", "status read count",
        rdCnt, (eR < 0) ? LIMIT : eR);
    badW = 0;
    for (int i = 0; i < expW; i++)
      if ({logA[i], logD[i]} != expCmd(op, i, a, d)) badW++;
    chk(wc == expW && badW == 0, "R2", "write sequence", wc * 100 + badW, expW * 100);
    chk(v3 == 0, "R3", "write strobe violations", v3, 0);
    chk(v4 == 0, "R4", "read/write separation violations", v4, 0);
    chk(v5 == 0, "R5", "read window violations", v5, 0);
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    chk(1'b0, "WATCHDOG", "run hung", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int op, busy, gl, ign;
    logic [15:0] a;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(flCeN && flWeN && flOeN && !flDoe, "R1", "strobes idle in reset",
        {flCeN, flWeN, flOeN, flDoe}, 4'b1110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady && !respValid && flCeN && flWeN && flOeN && !flDoe, "R1",
        "idle after reset", {reqReady, respValid}, 2'b10);

    // directed corners
    doOp(0, 16'h1234, 8'h5A, 5, 0);            // normal program
    doOp(0, 16'h1234, 8'hA5, 3, 0);            // not erased -> mismatch (R9)
    doOp(1, 16'h8ABC, 8'h00, 10, 4);           // sector erase, stalled toggle (R6)
    doOp(2, 16'h0040, 8'h00, 0, 0);            // chip erase finishing immediately
    doOp(0, 16'h0040, 8'h00, 7, 7);            // stall on last busy read
    doOp(0, 16'h0077, 8'h3C, 200, 0);          // timeout (R8)

    // R10: op code 3 ignored
    ign = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd3;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!flCeN || !flWeN || !flOeN || respValid || !reqReady) ign++;
    end
    reqValid = 1'b0;
    chk(ign == 0, "R10", "op 3 left bus and handshake untouched", ign, 0);

    // constrained random
    for (int k = 0; k < 14; k++) begin
      op   = int'($urandom % 3);
      a    = 16'($urandom);
      d    = 8'($urandom);
      busy = int'($urandom % 31);
      gl   = (busy > 1 && ($urandom % 2 == 0)) ? 1 + int'($urandom % busy) : 0;
      doOp(op, a, d, busy, gl);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule